// File: doc/BRIEF.md
# Indirect-Access Interrupt Routing Register File

This block is the register front end of an I/O interrupt controller. Software sees three aligned 32-bit locations on a simple bus: a byte-wide select register, a data window and an end-of-interrupt port. The select value picks one internal register, and the window reads or writes it. The internal registers are a fixed version word, a 4-bit identifier (also visible under a second, read-only arbitration index) and a table of 64-bit routing entries. Each entry is reached as a pair of 32-bit halves. Even select values reach the low half and odd values reach the high half.

The block stores the table and exports each pin's mask and trigger-mode bits to the servicing logic. That logic sets an entry's remote-IRR status bit through a per-pin input, and software clears it by writing the entry's low half. When a low-half write changes the mask, trigger-mode or polarity bit of an entry, the block raises a one-cycle re-evaluation pulse that carries the entry index. A write to the end-of-interrupt port forwards its vector to the servicing logic as a one-cycle level-type acknowledge. Interrupt delivery is done elsewhere.

Top module: `intc_regwin`

## Requirements
- R1: A write to bus offset 0x00 keeps only bits 7:0 of the data as the select value. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01, a window read returns (pin count − 1) in bits 23:16 and the 8-bit version code in bits 7:0, with all other bits zero. Window writes to this index change nothing.
- R3: With select 0x00, a window write stores data bits 27:24 as the identifier. Window reads at select 0x00 and select 0x02 both return the identifier in bits 27:24 and zero elsewhere. Window writes at select 0x02 are ignored. Selects 0x03 to 0x0F read as zero.
- R4: A select s ≥ 0x10 addresses entry (s − 0x10) >> 1 through the window (offset 0x10). An odd s reaches entry bits 63:32 and an even s reaches bits 31:0.
- R5: A window read of an entry index at or beyond the pin count returns 0xFFFFFFFF. A window write to such an index leaves every entry unchanged.
- R6: Remote-IRR is entry bit 14. It is set by a one on the pin's rirr_set input. Any low-half write to the entry clears it, whatever the data's bit 14. A high-half write leaves it unchanged.
- R7: After reset the select and identifier are zero. Every entry's low half reads 0x00010000 (mask, bit 16, set) and its high half reads zero. No output pulse is active.
- R8: A write to offset 0x40 makes eoi_valid high for exactly the next cycle, with eoi_vector equal to data bits 7:0.
- R9: When rirr_set for a pin and a low-half write to the same entry fall in one cycle, the entry's remote-IRR ends up set.
- R10: The cycle after a low-half write that changes entry bit 16 (mask), bit 15 (trigger mode, 1 = level) or bit 13 (polarity), reeval_valid is high for one cycle with reeval_index equal to the entry index. Writes that leave those three bits unchanged, and all high-half writes, raise no pulse.
- R11: Only accesses with bus_addr[1:0] = 0 to offsets 0x00, 0x10 and 0x40 take effect. Every read returns data with bus_rvalid high in the following cycle, and a read of any other address returns zero.
- R12: ent_mask[i] and ent_level[i] always equal bit 16 and bit 15 of entry i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset within the block |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data returned this cycle |
| rirr_set | input | NPINS | Per-pin request to set remote-IRR |
| ent_mask | output | NPINS | Mask bit of each entry |
| ent_level | output | NPINS | Trigger-mode bit of each entry |
| ent_rirr | output | NPINS | Remote-IRR bit of each entry |
| eoi_valid | output | 1 | Acknowledge pulse |
| eoi_vector | output | 8 | Vector carried by the acknowledge |
| reeval_valid | output | 1 | Entry settings changed pulse |
| reeval_index | output | $clog2(NPINS) | Entry whose settings changed |

## Verification
A remote-IRR set from the servicing side and a software write to the same entry's low half can land in the same clock cycle. That write would clear the bit. The bench drives rirr_set for one pin on the same clock edge as a low-half window write to that pin's entry. It then checks that ent_rirr stays set and that a later window read shows bit 14 as one. A separate step checks that an ordinary low-half write clears the bit and that a high-half write does not.

// File: rtl/intc_regwin_pkg.sv
// Shared constants and types for the indirect interrupt register file.
// Assumes a 32-bit data bus and an 8-bit byte offset.
package intc_regwin_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // Bus offsets of the three visible locations
    localparam logic [7:0] OFS_SEL = 8'h00;
    localparam logic [7:0] OFS_WIN = 8'h10;
    localparam logic [7:0] OFS_EOI = 8'h40;

    // Select values of the internal registers
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TAB_BASE = 8'h10;

    // Entry bit positions that the servicing logic decodes
    localparam int F_POL  = 13;
    localparam int F_RIRR = 14;
    localparam int F_TRIG = 15;
    localparam int F_MASK = 16;

    localparam int ID_LSB = 24;
    localparam int ID_W   = 4;

    localparam logic [31:0] LO_RESET   = 32'h1 << F_MASK;
    localparam logic [31:0] RIRR_BIT   = 32'h1 << F_RIRR;
    localparam logic [31:0] SETTINGS_M = (32'h1 << F_MASK) | (32'h1 << F_TRIG) | (32'h1 << F_POL);

    // Decoded bus operation
    typedef struct packed {
        logic wr_sel;
        logic wr_win;
        logic wr_eoi;
        logic rd_sel;
        logic rd_win;
        logic rd_any;
    } bus_op_t;
endpackage

// File: rtl/intc_regwin_decode.sv
// Bus decoder: turns one access into per-location strobes.
// Assumes a single-cycle request; misaligned addresses hit nothing.
module intc_regwin_decode
    import intc_regwin_pkg::*;
(
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output bus_op_t           op
);
    logic aligned;

    // Strobe generation from address, direction and alignment
    always_comb begin
        aligned   = (bus_addr[1:0] == 2'b00);
        op.wr_sel = bus_en &  bus_wr & aligned & (bus_addr == OFS_SEL);
        op.wr_win = bus_en &  bus_wr & aligned & (bus_addr == OFS_WIN);
        op.wr_eoi = bus_en &  bus_wr & aligned & (bus_addr == OFS_EOI);
        op.rd_sel = bus_en & ~bus_wr & aligned & (bus_addr == OFS_SEL);
        op.rd_win = bus_en & ~bus_wr & aligned & (bus_addr == OFS_WIN);
        op.rd_any = bus_en & ~bus_wr;
    end
endmodule

// File: rtl/intc_regwin_index.sv
// Maps the select value to a table entry index and half.
// Assumes NPINS is no larger than 120, so the index fits in 8 bits.
module intc_regwin_index
    import intc_regwin_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic [7:0]       sel,
    output logic             tab_hit,
    output logic             tab_in_range,
    output logic             tab_hi,
    output logic [IDX_W-1:0] tab_idx
);
    logic [7:0] idx_full;

    // Entry number, half and range check from the select value
    always_comb begin
        tab_hit      = (sel >= SEL_TAB_BASE);
        idx_full     = (sel - SEL_TAB_BASE) >> 1;
        tab_in_range = tab_hit && (idx_full < 8'(NPINS));
        tab_hi       = sel[0];
        tab_idx      = idx_full[IDX_W-1:0];
    end
endmodule

// File: rtl/intc_regwin_table.sv
// Routing entry storage: NPINS entries of two 32-bit halves plus a
// remote-IRR flag each. One write port and one read port, both
// indexed. Emits a pulse when a low-half write changes the settings.
// Assumes wr_idx < NPINS whenever wr_en is high.
module intc_regwin_table
    import intc_regwin_pkg::*;
#(
    parameter int NPINS = 24,
    localparam int IDX_W = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_hi,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [31:0]      wr_data,
    input  logic [NPINS-1:0] rirr_set,
    input  logic             rd_hi,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic [NPINS-1:0] ent_mask,
    output logic [NPINS-1:0] ent_level,
    output logic [NPINS-1:0] ent_rirr,
    output logic             reeval_valid,
    output logic [IDX_W-1:0] reeval_index
);
    logic [NPINS-1:0][31:0] lo_arr;
    logic [NPINS-1:0][31:0] hi_arr;
    logic [31:0]            cur_lo;
    logic                   chg;

    for (genvar g = 0; g < NPINS; g++) begin : g_ent
        logic [31:0] lo_q;
        logic [31:0] hi_q;
        logic        rirr_q;
        logic        hit;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        // Entry halves: reset to masked, load on a write hit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= LO_RESET;
                hi_q <= '0;
            end else if (hit) begin
                if (wr_hi) hi_q <= wr_data;
                else       lo_q <= wr_data & ~RIRR_BIT;
            end
        end

        // Remote-IRR flag: set from servicing side wins over clear by low write
        always_ff @(posedge clk) begin
            if (!rst_n)                rirr_q <= 1'b0;
            else if (rirr_set[g])      rirr_q <= 1'b1;
            else if (hit && !wr_hi)    rirr_q <= 1'b0;
        end

        assign lo_arr[g]    = lo_q | (rirr_q ? RIRR_BIT : 32'h0);
        assign hi_arr[g]    = hi_q;
        assign ent_mask[g]  = lo_q[F_MASK];
        assign ent_level[g] = lo_q[F_TRIG];
        assign ent_rirr[g]  = rirr_q;
    end

    // Read port and current low half of the write target
    always_comb begin
        rd_data = '0;
        cur_lo  = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = rd_hi ? hi_arr[i] : lo_arr[i];
            if (wr_idx == IDX_W'(i)) cur_lo  = lo_arr[i];
        end
        chg = wr_en && !wr_hi && (((cur_lo ^ wr_data) & SETTINGS_M) != 32'h0);
    end

    // Settings-change pulse, one cycle after the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reeval_valid <= 1'b0;
            reeval_index <= '0;
        end else begin
            reeval_valid <= chg;
            if (chg) reeval_index <= wr_idx;
        end
    end
endmodule

// File: rtl/intc_regwin.sv
// Top of the indirect interrupt register file. Holds the select and
// identifier registers, forwards acknowledges, and builds the read data.
// Assumes aligned 32-bit accesses; all others are ignored or read zero.
module intc_regwin
    import intc_regwin_pkg::*;
#(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         IDX_W   = $clog2(NPINS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             bus_wr,
    input  logic [7:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    output logic             bus_rvalid,
    input  logic [NPINS-1:0] rirr_set,
    output logic [NPINS-1:0] ent_mask,
    output logic [NPINS-1:0] ent_level,
    output logic [NPINS-1:0] ent_rirr,
    output logic             eoi_valid,
    output logic [7:0]       eoi_vector,
    output logic             reeval_valid,
    output logic [IDX_W-1:0] reeval_index
);
    bus_op_t          op;
    logic [7:0]       sel_q;
    logic [ID_W-1:0]  id_q;
    logic             tab_hit;
    logic             tab_in_range;
    logic             tab_hi;
    logic [IDX_W-1:0] tab_idx;
    logic [31:0]      tab_rd;
    logic [31:0]      win_rd;
    logic [31:0]      rd_next;
    logic [31:0]      id_word;

    intc_regwin_decode u_dec (
        .bus_en   (bus_en),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .op       (op)
    );

    intc_regwin_index #(.NPINS(NPINS)) u_idx (
        .sel          (sel_q),
        .tab_hit      (tab_hit),
        .tab_in_range (tab_in_range),
        .tab_hi       (tab_hi),
        .tab_idx      (tab_idx)
    );

    intc_regwin_table #(.NPINS(NPINS)) u_tab (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (op.wr_win && tab_in_range),
        .wr_hi        (tab_hi),
        .wr_idx       (tab_idx),
        .wr_data      (bus_wdata),
        .rirr_set     (rirr_set),
        .rd_hi        (tab_hi),
        .rd_idx       (tab_idx),
        .rd_data      (tab_rd),
        .ent_mask     (ent_mask),
        .ent_level    (ent_level),
        .ent_rirr     (ent_rirr),
        .reeval_valid (reeval_valid),
        .reeval_index (reeval_index)
    );

    // Select register: low byte of a write to the select offset
    always_ff @(posedge clk) begin
        if (!rst_n)         sel_q <= '0;
        else if (op.wr_sel) sel_q <= bus_wdata[7:0];
    end

    // Identifier register: written only through the window at its own index
    always_ff @(posedge clk) begin
        if (!rst_n)                              id_q <= '0;
        else if (op.wr_win && sel_q == SEL_ID)   id_q <= bus_wdata[ID_LSB +: ID_W];
    end

    // Acknowledge forwarding: one-cycle pulse with the written vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_valid  <= 1'b0;
            eoi_vector <= '0;
        end else begin
            eoi_valid <= op.wr_eoi;
            if (op.wr_eoi) eoi_vector <= bus_wdata[7:0];
        end
    end

    // Window read data from the select value
    always_comb begin
        id_word = 32'(id_q) << ID_LSB;
        if (sel_q == SEL_ID || sel_q == SEL_ARB)
            win_rd = id_word;
        else if (sel_q == SEL_VER)
            win_rd = {8'h00, 8'(NPINS - 1), 8'h00, VERSION};
        else if (!tab_hit)
            win_rd = '0;
        else if (!tab_in_range)
            win_rd = '1;
        else
            win_rd = tab_rd;
    end

    // Bus read data selection
    always_comb begin
        if (op.rd_sel)      rd_next = {24'h0, sel_q};
        else if (op.rd_win) rd_next = win_rd;
        else                rd_next = '0;
    end

    // Registered read response
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            bus_rdata  <= '0;
        end else begin
            bus_rvalid <= op.rd_any;
            if (op.rd_any) bus_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/intc_regwin_chk.sv
// Property checker for intc_regwin, attached by bind below.
module intc_regwin_chk #(
    parameter int          NPINS   = 24,
    parameter logic [7:0]  VERSION = 8'h11,
    localparam int         IDX_W   = $clog2(NPINS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_en,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic [31:0]      bus_rdata,
    input logic             bus_rvalid,
    input logic [NPINS-1:0] rirr_set,
    input logic [NPINS-1:0] ent_rirr,
    input logic             eoi_valid,
    input logic [7:0]       eoi_vector,
    input logic             reeval_valid,
    input logic [IDX_W-1:0] reeval_index,
    input logic [7:0]       sel_q,
    input logic             tab_in_range,
    input logic             tab_hi,
    input logic [IDX_W-1:0] tab_idx
);
    logic wr_sel_c, wr_win_c, rd_win_c, wr_eoi_c, lo_wr_c;
    logic [7:0] sel_ofs;

    always_comb begin
        wr_sel_c = bus_en && bus_wr && bus_addr == 8'h00;
        wr_win_c = bus_en && bus_wr && bus_addr == 8'h10;
        wr_eoi_c = bus_en && bus_wr && bus_addr == 8'h40;
        rd_win_c = bus_en && !bus_wr && bus_addr == 8'h10;
        lo_wr_c  = wr_win_c && tab_in_range && !tab_hi;
        sel_ofs  = (sel_q - 8'h10) >> 1;
    end

    assert_sel_low_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel_c |=> sel_q == $past(bus_wdata[7:0]));

    assert_version_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win_c && sel_q == 8'h01) |=> bus_rdata == {8'h00, 8'(NPINS - 1), 8'h00, VERSION});

    assert_beyond_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_win_c && sel_q >= 8'h10 && sel_ofs >= 8'(NPINS)) |=> bus_rdata == 32'hFFFF_FFFF);

    assert_low_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_wr_c && !rirr_set[tab_idx]) |=> !ent_rirr[$past(tab_idx)]);

    assert_eoi_forward_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eoi_c |=> (eoi_valid && eoi_vector == $past(bus_wdata[7:0])));

    assert_eoi_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_valid |-> $past(wr_eoi_c));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set != '0) |=> ((ent_rirr & $past(rirr_set)) == $past(rirr_set)));

    assert_reeval_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reeval_valid |-> ($past(lo_wr_c) && reeval_index == $past(tab_idx)));

    assert_read_response_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid == $past(bus_en && !bus_wr));
endmodule

bind intc_regwin intc_regwin_chk #(.NPINS(NPINS), .VERSION(VERSION)) u_chk (.*);

// File: tb/intc_regwin_bench.sv
module intc_regwin_bench;
    localparam int NP  = 24;
    localparam int IW  = $clog2(NP);
    localparam logic [7:0] VER = 8'h11;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          bus_rvalid;
    logic [NP-1:0] rirr_set = '0;
    logic [NP-1:0] ent_mask, ent_level, ent_rirr;
    logic          eoi_valid;
    logic [7:0]    eoi_vector;
    logic          reeval_valid;
    logic [IW-1:0] reeval_index;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference model built from the requirements
    logic [31:0] m_lo [NP];
    logic [31:0] m_hi [NP];
    logic [NP-1:0] m_rirr;
    logic [3:0]  m_id;
    logic        last_rv;

    always #10 clk = ~clk;

    intc_regwin u_intc_regwin (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata; last_rv = bus_rvalid;
        bus_en = 1'b0;
    endtask

    task automatic win_read(input logic [7:0] s, output logic [31:0] d);
        bus_write(8'h00, {24'h0, s});
        bus_read(8'h10, d);
    endtask

    task automatic win_write(input logic [7:0] s, input logic [31:0] d);
        bus_write(8'h00, {24'h0, s});
        bus_write(8'h10, d);
    endtask

    function automatic logic [31:0] exp_win(input logic [7:0] s);
        int idx;
        if (s == 8'h00 || s == 8'h02) return {4'h0, m_id, 24'h0};
        if (s == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VER};
        if (s < 8'h10) return 32'h0;
        idx = (int'(s) - 16) / 2;
        if (idx >= NP) return 32'hFFFF_FFFF;
        return s[0] ? m_hi[idx] : (m_lo[idx] | (m_rirr[idx] ? 32'h4000 : 32'h0));
    endfunction

    function automatic logic [31:0] pat_lo(input int i);
        return (32'(i) * 32'h0003_A107) ^ 32'h5A00_0000;
    endfunction

    function automatic logic [31:0] pat_hi(input int i);
        return {8'(i * 7 + 3), 24'h12_3400} ^ 32'(i);
    endfunction

    task automatic sweep(input string req, input int lo_s, input int hi_s);
        logic [31:0] d;
        for (int s = lo_s; s <= hi_s; s++) begin
            win_read(8'(s), d);
            check(d == exp_win(8'(s)) && last_rv, req, d, exp_win(8'(s)));
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [31:0] v;
        for (int i = 0; i < NP; i++) begin m_lo[i] = 32'h0001_0000; m_hi[i] = '0; end
        m_rirr = '0; m_id = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state at the ports
        check(!bus_rvalid && !eoi_valid && !reeval_valid, "R7 pulses idle", {29'h0, bus_rvalid, eoi_valid, reeval_valid}, 32'h0);
        check(ent_mask == '1 && ent_rirr == '0 && ent_level == '0, "R7 entry bits", 32'(ent_mask), 32'hFF_FFFF);
        bus_read(8'h00, d);
        check(d == 32'h0 && last_rv, "R7 select zero", d, 32'h0);

        // R2 R3 R4 R5 R7: full select sweep after reset
        sweep("R7 reset sweep", 0, 255);

        // R2: version write ignored
        win_write(8'h01, 32'hFFFF_FFFF);
        win_read(8'h01, d);
        check(d == exp_win(8'h01), "R2 version write ignored", d, exp_win(8'h01));

        // R3: identifier write, arbitration view, arbitration write ignored
        win_write(8'h00, 32'hA5FF_FFFF); m_id = 4'h5;
        win_read(8'h00, d);
        check(d == 32'h0500_0000, "R3 id read", d, 32'h0500_0000);
        win_read(8'h02, d);
        check(d == 32'h0500_0000, "R3 arb read", d, 32'h0500_0000);
        win_write(8'h02, 32'h0F00_0000);
        win_read(8'h00, d);
        check(d == 32'h0500_0000, "R3 arb write ignored", d, 32'h0500_0000);

        // R1: only the low byte of a select write
        bus_write(8'h00, 32'hABCD_1234);
        bus_read(8'h00, d);
        check(d == 32'h0000_0034, "R1 select low byte", d, 32'h34);

        // R4 R12: fill every entry and compare exported bits
        for (int i = 0; i < NP; i++) begin
            win_write(8'(16 + 2 * i + 1), pat_hi(i)); m_hi[i] = pat_hi(i);
            win_write(8'(16 + 2 * i), pat_lo(i));     m_lo[i] = pat_lo(i) & ~32'h4000;
        end
        for (int i = 0; i < NP; i++) begin
            check(ent_mask[i] == m_lo[i][16] && ent_level[i] == m_lo[i][15], "R12 exported bits",
                  {30'h0, ent_mask[i], ent_level[i]}, {30'h0, m_lo[i][16], m_lo[i][15]});
        end
        sweep("R4 table sweep", 16, 255);

        // R5: writes beyond the table are discarded
        win_write(8'h40, 32'hDEAD_BEEF);
        win_write(8'h41, 32'hDEAD_BEEF);
        win_write(8'hFF, 32'hDEAD_BEEF);
        sweep("R5 after discarded writes", 16, 16 + 2 * NP + 1);

        // R6: remote-IRR set, kept by high write, cleared by low write
        @(negedge clk); rirr_set = NP'(1) << 3;
        @(negedge clk); rirr_set = '0; m_rirr[3] = 1'b1;
        check(ent_rirr[3] == 1'b1, "R6 set by input", 32'(ent_rirr), 32'h8);
        win_read(8'h16, d);
        check(d == exp_win(8'h16) && d[14], "R6 read bit 14", d, exp_win(8'h16));
        win_write(8'h17, 32'h1111_2222); m_hi[3] = 32'h1111_2222;
        check(ent_rirr[3] == 1'b1, "R6 high write keeps", 32'(ent_rirr), 32'h8);
        win_write(8'h16, m_lo[3] | 32'h4000); m_rirr[3] = 1'b0;
        check(ent_rirr[3] == 1'b0, "R6 low write clears", 32'(ent_rirr), 32'h0);
        win_read(8'h16, d);
        check(d == exp_win(8'h16), "R6 read cleared", d, exp_win(8'h16));

        // R9: set and clear in the same cycle
        bus_write(8'h00, 32'h0000_001A);
        @(negedge clk);
        bus_en = 1'b1; bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_0031;
        rirr_set = NP'(1) << 5;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0; rirr_set = '0;
        m_lo[5] = 32'h0000_0031; m_rirr[5] = 1'b1;
        check(ent_rirr[5] == 1'b1, "R9 set wins", 32'(ent_rirr), 32'h20);
        bus_read(8'h10, d);
        check(d == exp_win(8'h1A), "R9 read bit 14", d, exp_win(8'h1A));

        // R10: settings-change pulse
        bus_write(8'h00, 32'h0000_001E);
        v = m_lo[7];
        bus_write(8'h10, v);
        check(!reeval_valid, "R10 same value no pulse", {31'h0, reeval_valid}, 32'h0);
        v = v ^ 32'h0001_0000; m_lo[7] = v;
        bus_write(8'h10, v);
        check(reeval_valid && reeval_index == IW'(7), "R10 mask toggle", {27'h0, reeval_index}, 32'h7);
        @(negedge clk);
        check(!reeval_valid, "R10 one cycle", {31'h0, reeval_valid}, 32'h0);
        v = v ^ 32'h0000_00FF; m_lo[7] = v;
        bus_write(8'h10, v);
        check(!reeval_valid, "R10 vector change no pulse", {31'h0, reeval_valid}, 32'h0);
        v = v ^ 32'h0000_2000; m_lo[7] = v;
        bus_write(8'h10, v);
        check(reeval_valid && reeval_index == IW'(7), "R10 polarity toggle", {27'h0, reeval_index}, 32'h7);
        v = v ^ 32'h0000_8000; m_lo[7] = v;
        bus_write(8'h10, v);
        check(reeval_valid && ent_level[7] == v[15], "R10 trigger toggle", {31'h0, reeval_valid}, 32'h1);
        bus_write(8'h00, 32'h0000_001F);
        bus_write(8'h10, 32'hFFFF_FFFF); m_hi[7] = 32'hFFFF_FFFF;
        check(!reeval_valid, "R10 high write no pulse", {31'h0, reeval_valid}, 32'h0);

        // R8: acknowledge forwarding
        bus_write(8'h40, 32'h1234_56C3);
        check(eoi_valid && eoi_vector == 8'hC3, "R8 eoi pulse", {24'h0, eoi_vector}, 32'hC3);
        @(negedge clk);
        check(!eoi_valid, "R8 eoi one cycle", {31'h0, eoi_valid}, 32'h0);

        // R11: misaligned and unmapped accesses
        bus_write(8'h00, 32'h0000_0012);
        bus_write(8'h01, 32'h0000_0077);
        bus_write(8'h41, 32'h0000_0099);
        check(!eoi_valid, "R11 misaligned eoi ignored", {31'h0, eoi_valid}, 32'h0);
        bus_read(8'h00, d);
        check(d == 32'h12, "R11 misaligned write ignored", d, 32'h12);
        bus_read(8'h11, d);
        check(d == 32'h0 && last_rv, "R11 misaligned read zero", d, 32'h0);
        bus_read(8'h20, d);
        check(d == 32'h0 && last_rv, "R11 unmapped read zero", d, 32'h0);
        bus_read(8'h40, d);
        check(d == 32'h0 && last_rv, "R11 eoi read zero", d, 32'h0);

        // Final table sweep: nothing above disturbed other entries
        sweep("R4 final sweep", 16, 16 + 2 * NP + 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule